// File: doc/BRIEF.md
# SDRAM Burst Access Sequencer

This block turns one user request into a complete, self-contained access to an already initialized SDRAM device. A request names the direction, the bank, the row, the starting column, a full burst of write data and a per-word byte-enable pattern. The sequencer opens the row, waits the row-to-column delay, and issues a column command with auto-precharge disabled. It then streams a fixed-length burst of consecutive words and closes the row with a single-bank precharge. Before it takes the next request it honors the write-recovery time and the precharge period.

Read words arrive on the data input a fixed CAS latency after the READ command. The block registers each one and hands it to the user with a one-cycle valid strobe. All command, address, mask and data outputs come from registers. The data bus is split into an output, an output enable and an input, so the pad tristate sits outside the block. The block does not power up or refresh the device. A refresh scheduler next to it waits for the idle flag before it takes over the pins.

Top module: `sdram_burst_seq`

## Requirements
- R1: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. In the next cycle the command pins {cs_n,ras_n,cas_n,we_n} show ACTIVE (4'b0011), with the request bank on `sd_ba` and the row on `sd_addr`.
- R2: The column command comes exactly T_RCD cycles after ACTIVE and carries the request bank. `sd_addr` holds the column in its low bits, with bit 10 and every other upper bit at zero, so there is no auto-precharge. It is WRITE (4'b0100) for a write and READ (4'b0101) for a read, so only we_n differs.
- R3: For a write, burst word k (bits [16k+15:16k] of `req_wdata`) is driven on `sd_dq_o` k cycles after the WRITE command, for k = 0..BURST_LEN-1. `sd_dq_oe` is high in exactly those BURST_LEN cycles.
- R4: While a write word is driven, `sd_dqm` is the inverse of that word's byte enables (bits [2k+1:2k] of `req_be`, bit 1 = upper byte), so a high mask bit protects its byte. `sd_dqm` is zero in every other cycle.
- R5: For a read, the word on `sd_dq_i` CAS_LAT+k cycles after READ is returned on `rd_data` one cycle later, with `rd_valid` high for that single cycle. `rd_valid` is low at all other times.
- R6: After a write, a precharge (4'b0010) to the same bank, with `sd_addr` zero (bit 10 low, single bank), is issued T_WR cycles after the last write word.
- R7: After a read, the same single-bank precharge is issued BURST_LEN cycles after the READ command.
- R8: `req_ready` is low from the ACTIVE cycle until T_RP-1 cycles after the precharge, and high again then. A request held ready at that cycle therefore places its ACTIVE exactly T_RP cycles after the precharge.
- R9: In every other cycle, including during and straight after reset, the command pins show NOP (4'b0111) and `sd_addr` is zero.
- R10: `idle` is high only when `req_ready` is high and no read word is still in flight. After a read it stays low through the cycle of the last `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the SDRAM device |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can accept a request this cycle |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Row to open |
| req_col | input | COL_W | Starting column of the burst |
| req_wdata | input | BURST_LEN*DATA_W | Write words, word 0 in the low bits |
| req_be | input | BURST_LEN*DATA_W/8 | Byte enables per write word, high = write the byte |
| rd_data | output | DATA_W | Returned read word |
| rd_valid | output | 1 | One-cycle strobe for each returned word |
| idle | output | 1 | No access open and no read data pending |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank address |
| sd_addr | output | ROW_W | Multiplexed row/column address |
| sd_dqm | output | DATA_W/8 | Byte mask, high = masked |
| sd_dq_o | output | DATA_W | Data toward the device |
| sd_dq_oe | output | 1 | Drive enable for the data pads |
| sd_dq_i | input | DATA_W | Data from the device |

## Verification
Every result has a fixed distance from the accepting edge. ACTIVE lands 1 cycle after acceptance and the column command 1+T_RCD cycles after it. Write words follow one per cycle from the column command onward, and the precharge comes T_WR cycles after the last write word or BURST_LEN cycles after a READ. `req_ready` comes back T_RP-1 cycles after the precharge, and each read word leaves as `rd_valid` CAS_LAT+1 cycles after the READ plus its beat index. At acceptance the bench writes every expected value into a ring indexed by absolute cycle number, including the read words it will drive onto the data input. It compares the outputs against that ring at each falling edge, so overlapping back-to-back accesses are checked cycle-exact without any model of the design's state.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    // Command encoding on {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_NOP = 4'b0111,
        CMD_ACT = 4'b0011,
        CMD_RD  = 4'b0101,
        CMD_WR  = 4'b0100,
        CMD_PRE = 4'b0010
    } sd_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RCD,
        ST_BURST,
        ST_WREC,
        ST_RP
    } seq_state_e;

    // Address bit that requests auto-precharge on a column command
    localparam int AP_BIT = 10;

    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic int sat_sub(input int a, input int b);
        return (a > b) ? a - b : 0;
    endfunction

endpackage

// File: rtl/sdram_seq_ctrl.sv
module sdram_seq_ctrl
    import sdram_seq_pkg::*;
#(
    parameter int BANK_W    = 2,
    parameter int ROW_W     = 12,
    parameter int COL_W     = 9,
    parameter int BURST_LEN = 4,
    parameter int T_RCD     = 2,
    parameter int T_WR      = 2,
    parameter int T_RP      = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          req_valid,
    input  logic                          req_write,
    input  logic [BANK_W-1:0]             req_bank,
    input  logic [ROW_W-1:0]              req_row,
    input  logic [COL_W-1:0]              req_col,
    output logic                          req_ready,
    output sd_cmd_e                       cmd_q,
    output logic [BANK_W-1:0]             ba_q,
    output logic [ROW_W-1:0]              addr_q,
    output logic                          wr_drv_nxt,
    output logic [idx_w(BURST_LEN)-1:0]   wr_beat_nxt,
    output logic                          rd_strobe
);

    localparam int BEAT_W = idx_w(BURST_LEN);
    localparam int CNT_W  = idx_w(max3(T_RCD, T_WR, T_RP));
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_LEN - 1);

    typedef struct packed {
        logic              wr;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  col;
    } held_req_t;

    seq_state_e          st_q, st_n;
    logic [CNT_W-1:0]    cnt_q, cnt_n;
    logic [BEAT_W-1:0]   beat_q, beat_n;
    held_req_t           req_q, req_n;
    sd_cmd_e             cmd_n;
    logic [BANK_W-1:0]   ba_n;
    logic [ROW_W-1:0]    addr_n;
    logic [ROW_W-1:0]    col_addr;

    always_comb begin
        col_addr         = ROW_W'(req_q.col);
        col_addr[AP_BIT] = 1'b0;
    end

    always_comb begin
        st_n        = st_q;
        cnt_n       = cnt_q;
        beat_n      = beat_q;
        req_n       = req_q;
        cmd_n       = CMD_NOP;
        ba_n        = ba_q;
        addr_n      = '0;
        wr_drv_nxt  = 1'b0;
        wr_beat_nxt = '0;
        unique case (st_q)
            ST_IDLE: begin
                if (req_valid) begin
                    req_n.wr   = req_write;
                    req_n.bank = req_bank;
                    req_n.col  = req_col;
                    cmd_n      = CMD_ACT;
                    ba_n       = req_bank;
                    addr_n     = req_row;
                    st_n       = ST_RCD;
                    cnt_n      = CNT_W'(sat_sub(T_RCD, 1));
                end
            end
            ST_RCD: begin
                if (cnt_q == '0) begin
                    cmd_n      = req_q.wr ? CMD_WR : CMD_RD;
                    ba_n       = req_q.bank;
                    addr_n     = col_addr;
                    st_n       = ST_BURST;
                    beat_n     = '0;
                    wr_drv_nxt = req_q.wr;
                end else begin
                    cnt_n = cnt_q - 1'b1;
                end
            end
            ST_BURST: begin
                if (beat_q == LAST_BEAT) begin
                    if (req_q.wr && (T_WR > 1)) begin
                        st_n  = ST_WREC;
                        cnt_n = CNT_W'(sat_sub(T_WR, 2));
                    end else begin
                        cmd_n  = CMD_PRE;
                        ba_n   = req_q.bank;
                        st_n   = (T_RP > 1) ? ST_RP : ST_IDLE;
                        cnt_n  = CNT_W'(sat_sub(T_RP, 2));
                    end
                end else begin
                    beat_n      = beat_q + 1'b1;
                    wr_drv_nxt  = req_q.wr;
                    wr_beat_nxt = beat_q + 1'b1;
                end
            end
            ST_WREC: begin
                if (cnt_q == '0) begin
                    cmd_n = CMD_PRE;
                    ba_n  = req_q.bank;
                    st_n  = (T_RP > 1) ? ST_RP : ST_IDLE;
                    cnt_n = CNT_W'(sat_sub(T_RP, 2));
                end else begin
                    cnt_n = cnt_q - 1'b1;
                end
            end
            ST_RP: begin
                if (cnt_q == '0) begin
                    st_n = ST_IDLE;
                end else begin
                    cnt_n = cnt_q - 1'b1;
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            beat_q <= '0;
            req_q  <= '0;
            cmd_q  <= CMD_NOP;
            ba_q   <= '0;
            addr_q <= '0;
        end else begin
            st_q   <= st_n;
            cnt_q  <= cnt_n;
            beat_q <= beat_n;
            req_q  <= req_n;
            cmd_q  <= cmd_n;
            ba_q   <= ba_n;
            addr_q <= addr_n;
        end
    end

    assign req_ready = (st_q == ST_IDLE);
    assign rd_strobe = (st_q == ST_BURST) && !req_q.wr;

endmodule

// File: rtl/sdram_seq_wrdata.sv
module sdram_seq_wrdata
    import sdram_seq_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int BURST_LEN = 4
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              load,
    input  logic [BURST_LEN*DATA_W-1:0]       wdata_in,
    input  logic [BURST_LEN*(DATA_W/8)-1:0]   be_in,
    input  logic                              drv_nxt,
    input  logic [idx_w(BURST_LEN)-1:0]       beat_nxt,
    output logic [DATA_W-1:0]                 dq_o,
    output logic                              dq_oe,
    output logic [DATA_W/8-1:0]               dqm
);

    localparam int BE_W = DATA_W / 8;

    logic [DATA_W-1:0] word_q [BURST_LEN];
    logic [BE_W-1:0]   be_q   [BURST_LEN];

    for (genvar g = 0; g < BURST_LEN; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                word_q[g] <= '0;
                be_q[g]   <= '0;
            end else if (load) begin
                word_q[g] <= wdata_in[g*DATA_W +: DATA_W];
                be_q[g]   <= be_in[g*BE_W +: BE_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dq_o  <= '0;
            dq_oe <= 1'b0;
            dqm   <= '0;
        end else if (drv_nxt) begin
            dq_o  <= word_q[beat_nxt];
            dq_oe <= 1'b1;
            dqm   <= ~be_q[beat_nxt];
        end else begin
            dq_o  <= '0;
            dq_oe <= 1'b0;
            dqm   <= '0;
        end
    end

endmodule

// File: rtl/sdram_seq_rdcap.sv
module sdram_seq_rdcap #(
    parameter int DATA_W  = 16,
    parameter int CAS_LAT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  logic [DATA_W-1:0] dq_i,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              busy
);

    logic [CAS_LAT-1:0] pipe_q;

    if (CAS_LAT == 1) begin : g_lat1
        always_ff @(posedge clk) begin
            if (rst) pipe_q <= '0;
            else     pipe_q <= strobe;
        end
    end else begin : g_latn
        always_ff @(posedge clk) begin
            if (rst) pipe_q <= '0;
            else     pipe_q <= {pipe_q[CAS_LAT-2:0], strobe};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= pipe_q[CAS_LAT-1];
            if (pipe_q[CAS_LAT-1]) rd_data <= dq_i;
        end
    end

    assign busy = (|pipe_q) | rd_valid;

endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
    import sdram_seq_pkg::*;
#(
    parameter int BANK_W    = 2,
    parameter int ROW_W     = 12,
    parameter int COL_W     = 9,
    parameter int DATA_W    = 16,
    parameter int BURST_LEN = 4,
    parameter int T_RCD     = 2,
    parameter int CAS_LAT   = 2,
    parameter int T_WR      = 2,
    parameter int T_RP      = 2
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              req_valid,
    output logic                              req_ready,
    input  logic                              req_write,
    input  logic [BANK_W-1:0]                 req_bank,
    input  logic [ROW_W-1:0]                  req_row,
    input  logic [COL_W-1:0]                  req_col,
    input  logic [BURST_LEN*DATA_W-1:0]       req_wdata,
    input  logic [BURST_LEN*(DATA_W/8)-1:0]   req_be,
    output logic [DATA_W-1:0]                 rd_data,
    output logic                              rd_valid,
    output logic                              idle,
    output logic                              sd_cs_n,
    output logic                              sd_ras_n,
    output logic                              sd_cas_n,
    output logic                              sd_we_n,
    output logic [BANK_W-1:0]                 sd_ba,
    output logic [ROW_W-1:0]                  sd_addr,
    output logic [DATA_W/8-1:0]               sd_dqm,
    output logic [DATA_W-1:0]                 sd_dq_o,
    output logic                              sd_dq_oe,
    input  logic [DATA_W-1:0]                 sd_dq_i
);

    localparam int BEAT_W = idx_w(BURST_LEN);

    sd_cmd_e            cmd_q;
    logic               wr_drv_nxt;
    logic [BEAT_W-1:0]  wr_beat_nxt;
    logic               rd_strobe;
    logic               rd_busy;
    logic               accept;

    assign accept = req_valid & req_ready;

    sdram_seq_ctrl #(
        .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W),
        .BURST_LEN(BURST_LEN), .T_RCD(T_RCD), .T_WR(T_WR), .T_RP(T_RP)
    ) u_ctrl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .req_ready(req_ready),
        .cmd_q(cmd_q), .ba_q(sd_ba), .addr_q(sd_addr),
        .wr_drv_nxt(wr_drv_nxt), .wr_beat_nxt(wr_beat_nxt),
        .rd_strobe(rd_strobe)
    );

    sdram_seq_wrdata #(
        .DATA_W(DATA_W), .BURST_LEN(BURST_LEN)
    ) u_wrdata (
        .clk(clk), .rst(rst),
        .load(accept), .wdata_in(req_wdata), .be_in(req_be),
        .drv_nxt(wr_drv_nxt), .beat_nxt(wr_beat_nxt),
        .dq_o(sd_dq_o), .dq_oe(sd_dq_oe), .dqm(sd_dqm)
    );

    sdram_seq_rdcap #(
        .DATA_W(DATA_W), .CAS_LAT(CAS_LAT)
    ) u_rdcap (
        .clk(clk), .rst(rst),
        .strobe(rd_strobe), .dq_i(sd_dq_i),
        .rd_data(rd_data), .rd_valid(rd_valid), .busy(rd_busy)
    );

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
    assign idle = req_ready & ~rd_busy;

endmodule

// File: rtl/sdram_seq_chk.sv
module sdram_seq_chk
    import sdram_seq_pkg::*;
#(
    parameter int ROW_W  = 12,
    parameter int DATA_W = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                req_valid,
    input logic                req_ready,
    input logic                idle,
    input logic                sd_cs_n,
    input logic                sd_ras_n,
    input logic                sd_cas_n,
    input logic                sd_we_n,
    input logic [ROW_W-1:0]    sd_addr,
    input logic [DATA_W/8-1:0] sd_dqm,
    input logic                sd_dq_oe
);

    logic [3:0] cmd_w;
    logic       is_col;
    assign cmd_w  = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    assign is_col = (cmd_w == CMD_RD) || (cmd_w == CMD_WR);

    p_act_after_accept_r1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (cmd_w == CMD_ACT));

    p_col_no_autopre_r2: assert property (@(posedge clk) disable iff (rst)
        is_col |-> (sd_addr[AP_BIT] == 1'b0));

    p_oe_only_write_beats_r3: assert property (@(posedge clk) disable iff (rst)
        sd_dq_oe |-> ((cmd_w == CMD_WR) || (cmd_w == CMD_NOP)));

    p_dqm_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        !sd_dq_oe |-> (sd_dqm == '0));

    p_pre_single_bank_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd_w == CMD_PRE) |-> (sd_addr[AP_BIT] == 1'b0));

    p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    p_cmd_legal_r9: assert property (@(posedge clk) disable iff (rst)
        (cmd_w == CMD_NOP) || (cmd_w == CMD_ACT) || is_col || (cmd_w == CMD_PRE));

    p_idle_needs_ready_r10: assert property (@(posedge clk) disable iff (rst)
        idle |-> req_ready);

endmodule

bind sdram_burst_seq sdram_seq_chk #(
    .ROW_W(ROW_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .idle(idle),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_addr(sd_addr), .sd_dqm(sd_dqm), .sd_dq_oe(sd_dq_oe)
);

// File: tb/sdram_burst_seq_bench.sv
`timescale 1ns/1ps
module sdram_burst_seq_bench;

    localparam int BANK_W = 2;
    localparam int ROW_W  = 12;
    localparam int COL_W  = 9;
    localparam int DW     = 16;
    localparam int BL     = 4;
    localparam int T_RCD  = 2;
    localparam int CL     = 2;
    localparam int T_WR   = 2;
    localparam int T_RP   = 2;
    localparam int RING   = 64;

    localparam int TC   = 1 + T_RCD;
    localparam int TP_W = TC + BL - 1 + T_WR;
    localparam int TP_R = TC + BL;

    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_ACT = 4'b0011;
    localparam logic [3:0] C_RD  = 4'b0101;
    localparam logic [3:0] C_WR  = 4'b0100;
    localparam logic [3:0] C_PRE = 4'b0010;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic                 req_valid = 1'b0;
    logic                 req_ready;
    logic                 req_write = 1'b0;
    logic [BANK_W-1:0]    req_bank = '0;
    logic [ROW_W-1:0]     req_row = '0;
    logic [COL_W-1:0]     req_col = '0;
    logic [BL*DW-1:0]     req_wdata = '0;
    logic [BL*2-1:0]      req_be = '0;
    logic [DW-1:0]        rd_data;
    logic                 rd_valid;
    logic                 idle;
    logic                 sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [BANK_W-1:0]    sd_ba;
    logic [ROW_W-1:0]     sd_addr;
    logic [1:0]           sd_dqm;
    logic [DW-1:0]        sd_dq_o;
    logic                 sd_dq_oe;
    logic [DW-1:0]        sd_dq_i = '0;

    sdram_burst_seq #(
        .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DW),
        .BURST_LEN(BL), .T_RCD(T_RCD), .CAS_LAT(CL), .T_WR(T_WR), .T_RP(T_RP)
    ) u_sdram_burst_seq (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .req_wdata(req_wdata), .req_be(req_be),
        .rd_data(rd_data), .rd_valid(rd_valid), .idle(idle),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm),
        .sd_dq_o(sd_dq_o), .sd_dq_oe(sd_dq_oe), .sd_dq_i(sd_dq_i)
    );

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit mon_on = 1'b0;
    bit done   = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Expectation ring indexed by absolute cycle number
    logic [3:0]        e_cmd   [RING];
    logic [BANK_W-1:0] e_ba    [RING];
    logic [ROW_W-1:0]  e_addr  [RING];
    logic              e_prerd [RING];
    logic              e_oe    [RING];
    logic [DW-1:0]     e_dq    [RING];
    logic [1:0]        e_dqm   [RING];
    logic              e_rv    [RING];
    logic [DW-1:0]     e_rd    [RING];
    logic              e_rdy   [RING];
    logic              e_idle  [RING];
    logic              e_drv   [RING];
    logic [DW-1:0]     e_drvv  [RING];

    task automatic clear_slot(input int s);
        e_cmd[s] = C_NOP; e_ba[s] = '0; e_addr[s] = '0; e_prerd[s] = 1'b0;
        e_oe[s] = 1'b0; e_dq[s] = '0; e_dqm[s] = '0;
        e_rv[s] = 1'b0; e_rd[s] = '0; e_rdy[s] = 1'b1; e_idle[s] = 1'b1;
        e_drv[s] = 1'b0; e_drvv[s] = '0;
    endtask

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", tag, what, cyc, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] rd_word(input int bank, input int row, input int col, input int k);
        return DW'((row * 5) ^ (col << 3) ^ (bank << 13) ^ (k * 16'h1111) ^ 16'h2C07);
    endfunction

    // Per-cycle comparison at the falling edge
    always @(negedge clk) begin
        int s;
        string ctag;
        if (mon_on) begin
            s = cyc % RING;
            if (e_cmd[s] == C_ACT) ctag = "R1";
            else if (e_cmd[s] == C_RD || e_cmd[s] == C_WR) ctag = "R2";
            else if (e_cmd[s] == C_PRE) ctag = e_prerd[s] ? "R7" : "R6";
            else ctag = "R9";
            chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == e_cmd[s], ctag, "command",
                64'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 64'(e_cmd[s]));
            chk(sd_addr == e_addr[s], ctag, "address", 64'(sd_addr), 64'(e_addr[s]));
            if (e_cmd[s] != C_NOP)
                chk(sd_ba == e_ba[s], ctag, "bank", 64'(sd_ba), 64'(e_ba[s]));
            chk(sd_dq_oe == e_oe[s], "R3", "dq_oe", 64'(sd_dq_oe), 64'(e_oe[s]));
            if (e_oe[s])
                chk(sd_dq_o == e_dq[s], "R3", "write word", 64'(sd_dq_o), 64'(e_dq[s]));
            chk(sd_dqm == e_dqm[s], "R4", "dqm", 64'(sd_dqm), 64'(e_dqm[s]));
            chk(rd_valid == e_rv[s], "R5", "rd_valid", 64'(rd_valid), 64'(e_rv[s]));
            if (e_rv[s])
                chk(rd_data == e_rd[s], "R5", "rd_data", 64'(rd_data), 64'(e_rd[s]));
            chk(req_ready == e_rdy[s], "R8", "req_ready", 64'(req_ready), 64'(e_rdy[s]));
            chk(idle == e_idle[s], "R10", "idle", 64'(idle), 64'(e_idle[s]));
            if (e_drv[s]) sd_dq_i = e_drvv[s];
            else          sd_dq_i = DW'(cyc * 16'h3B1 ^ 16'hA5C3);
            clear_slot(s);
        end
    end

    // Issue one request at the current falling edge and return at the
    // falling edge of the cycle where the sequencer is ready again.
    task automatic do_txn(input bit wr, input int bank, input int row, input int col,
                          input logic [BL*DW-1:0] wd, input logic [BL*2-1:0] be);
        int c, tp, rdy_t, last_busy, s;
        c = cyc;
        tp = wr ? TP_W : TP_R;
        rdy_t = tp + T_RP - 1;
        last_busy = rdy_t - 1;
        if (!wr && (TC + CL + BL) > last_busy) last_busy = TC + CL + BL;

        req_valid = 1'b1; req_write = wr;
        req_bank = BANK_W'(bank); req_row = ROW_W'(row); req_col = COL_W'(col);
        req_wdata = wd; req_be = be;

        // R1: ACTIVE with bank and row
        s = (c + 1) % RING;
        e_cmd[s] = C_ACT; e_ba[s] = BANK_W'(bank); e_addr[s] = ROW_W'(row);
        // R2: column command, A10 low
        s = (c + TC) % RING;
        e_cmd[s] = wr ? C_WR : C_RD; e_ba[s] = BANK_W'(bank); e_addr[s] = ROW_W'(col);
        // R6 / R7: single-bank precharge
        s = (c + tp) % RING;
        e_cmd[s] = C_PRE; e_ba[s] = BANK_W'(bank); e_addr[s] = '0; e_prerd[s] = !wr;
        for (int t = 1; t < rdy_t; t++) e_rdy[(c + t) % RING] = 1'b0;
        for (int t = 1; t <= last_busy; t++) e_idle[(c + t) % RING] = 1'b0;
        for (int k = 0; k < BL; k++) begin
            if (wr) begin
                s = (c + TC + k) % RING;
                e_oe[s] = 1'b1; e_dq[s] = wd[k*DW +: DW]; e_dqm[s] = ~be[k*2 +: 2];
            end else begin
                s = (c + TC + CL + k) % RING;
                e_drv[s] = 1'b1; e_drvv[s] = rd_word(bank, row, col, k);
                s = (c + TC + CL + k + 1) % RING;
                e_rv[s] = 1'b1; e_rd[s] = rd_word(bank, row, col, k);
            end
        end

        @(negedge clk);
        req_valid = 1'b0;
        req_bank = ~req_bank; req_row = ~req_row; req_col = ~req_col;
        req_wdata = ~req_wdata; req_be = ~req_be; req_write = ~req_write;
        repeat (rdy_t - 1) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < RING; i++) clear_slot(i);
        repeat (3) @(negedge clk);
        // Reset state: R9 NOP, R8 ready, R10 idle, R3/R4/R5 quiet
        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, "R9", "reset command",
            64'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 64'(C_NOP));
        chk(req_ready == 1'b1, "R8", "reset ready", 64'(req_ready), 64'd1);
        chk(idle == 1'b1, "R10", "reset idle", 64'(idle), 64'd1);
        chk(sd_dq_oe == 1'b0, "R3", "reset oe", 64'(sd_dq_oe), 64'd0);
        chk(rd_valid == 1'b0, "R5", "reset rd_valid", 64'(rd_valid), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        mon_on = 1'b1;
        @(negedge clk);

        // Sweep: every bank, corner rows and columns, both directions,
        // all byte-enable combinations rotated across the burst words.
        for (int idx = 0; idx < 3; idx++) begin
            for (int bank = 0; bank < 4; bank++) begin
                for (int w = 1; w >= 0; w--) begin
                    int row, col;
                    logic [BL*DW-1:0] wd;
                    logic [BL*2-1:0]  be;
                    row = (idx == 0) ? 0 : (idx == 1) ? 12'hFFF : (12'h5A3 ^ bank);
                    col = (idx == 0) ? 0 : (idx == 1) ? 9'h1FF : (9'h0AC + bank);
                    for (int k = 0; k < BL; k++)
                        wd[k*DW +: DW] = DW'(16'h9E37 * (idx * 8 + bank * 2 + w + 1) + k * 16'h0101);
                    be = 8'b11_10_01_00;
                    be = (be << (2 * ((bank + idx) % 4))) | (be >> (8 - 2 * ((bank + idx) % 4)));
                    do_txn(w[0], bank, row, col, wd, be);
                end
                if (bank == 3) repeat (idx + 1) @(negedge clk);
            end
        end

        // A lone read followed by silence: idle stays low behind ready (R10)
        do_txn(1'b0, 2, 12'h321, 9'h040, '0, '0);
        repeat (12) @(negedge clk);
        finish_run();
    end

endmodule